// File: doc/BRIEF.md
# Programmable Down-Counter / Square-Wave Timer

This block is a 16-bit down-counter with two personalities. In timer mode, once started, it runs without stopping. It produces a square wave whose high and low phases each last as many enabled clock cycles as the value held in a preload register. In counter mode, a start command loads that value and counts it down once. It raises a ready flag and pulls the output low at terminal count, and keeps counting until a stop command halts it.

Software writes the preload one byte at a time, and the preload cannot be read back. It reads the live count one byte at a time through a byte selector. The count is only guaranteed coherent while the counter is halted. Clock source selection and prescaling are outside the block. Each cycle with `cnt_en_i` high counts as one counter clock. Start and stop are single-cycle command strobes, and their meaning depends on the mode.

Top module: `cnt_timer_top`

## Requirements
- R1: After reset, the ready flag is 0, the wave output is 1 and the count is 0x0000. The count does not move until the first start, in either mode.
- R2: A preload write with `pre_sel_i`=1 stores `pre_data_i` into bits 15:8, and with `pre_sel_i`=0 stores it into bits 7:0. The preload reaches the count only through a load.
- R3: In timer mode, the start cycle loads the preload N and drives the wave high. The wave toggles after every N cycles that have `cnt_en_i`=1, and the count is reloaded at each toggle, so the full period is 2N.
- R4: In timer mode, the ready flag is set at each low-to-high toggle, which is once per full square-wave period. The first time is 2N enabled cycles after start.
- R5: In timer mode, a stop clears the ready flag but does not halt the count or the wave.
- R6: A start while running ends the current cycle at once. The count is reloaded, the wave goes high and the ready flag is cleared.
- R7: In timer mode, a preload write does not change the half-period in progress. The new value is used from the next reload.
- R8: In counter mode, start loads the preload. The count then drops by one on each enabled cycle and holds while `cnt_en_i`=0.
- R9: In counter mode, when the count reaches 0x0000 the ready flag is set and the wave goes low. The count wraps to 0xFFFF and keeps counting down.
- R10: In counter mode, a stop halts the count at its current value, clears the ready flag and returns the wave high.
- R11: In counter mode, a preload write does not disturb a running count. The next start uses the new value, and a start with no new write reuses the previous value.
- R12: `rd_data_o` shows count bits 15:8 when `rd_sel_i`=1 and bits 7:0 when `rd_sel_i`=0, combinationally.
- R13: A start and a stop in the same cycle act as a start. A start in the same cycle as a preload write loads the preload as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_timer_i | input | 1 | 1 = timer mode, 0 = counter mode |
| cnt_en_i | input | 1 | Counter clock enable: one count per high cycle |
| start_i | input | 1 | Start command strobe |
| stop_i | input | 1 | Stop command strobe |
| pre_we_i | input | 1 | Preload byte write enable |
| pre_sel_i | input | 1 | Preload byte select (1 = high byte) |
| pre_data_i | input | 8 | Preload byte data |
| rd_sel_i | input | 1 | Count read-back byte select (1 = high byte) |
| rd_data_o | output | 8 | Selected byte of the live count |
| rdy_o | output | 1 | Counter-ready flag |
| wave_o | output | 1 | Square wave (timer) or terminal output (counter) |

## Verification
On every cycle, the assertions check the command effects. A stop always leaves the ready flag clear. A stop in counter mode halts counting and raises the wave, while in timer mode it leaves the timer running. A start always raises the wave. A timer reload takes the preload value and flips the wave. Counter-mode terminal count drives the flag high and the wave low, and an idle counter never moves. The exact half-period length, the first ready flag after two half-periods, and the boundary at which a mid-run preload write takes effect can only be shown by the bench's timed scenarios. The same holds for the wrap to 0xFFFF, the reuse of an old preload, and same-cycle start/stop and start/write collisions.

// File: rtl/cnt_timer_pkg.sv
`timescale 1ns/1ps
package cnt_timer_pkg;
  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_TIMER = 1'b1
  } ct_mode_e;
endpackage

// File: rtl/cnt_timer_rst_sync.sv
`timescale 1ns/1ps
module cnt_timer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cnt_timer_preload.sv
`timescale 1ns/1ps
module cnt_timer_preload #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NBYTES  = CNT_W / BYTE_W,
  parameter int unsigned SEL_W   = 1,
  parameter logic [CNT_W-1:0] PRE_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CNT_W-1:0]  pre_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_d;
    logic              lane_we;

    assign lane_we = we_i && (sel_i == SEL_W'(g));

    always_comb begin
      lane_d = lane_q;
      if (lane_we) lane_d = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= PRE_RST[g*BYTE_W +: BYTE_W];
      else         lane_q <= lane_d;
    end

    assign pre_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/cnt_timer_dcnt.sv
`timescale 1ns/1ps
module cnt_timer_dcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = pre_i;
    else if (dec_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign hit_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cnt_timer_ctrl.sv
`timescale 1ns/1ps
module cnt_timer_ctrl
  import cnt_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ct_mode_e mode_i,
  input  logic     cnt_en_i,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     hit_i,
  output logic     load_o,
  output logic     dec_o,
  output logic     run_o,
  output logic     wave_o,
  output logic     rdy_o
);
  logic run_q, run_d;
  logic wave_q, wave_d;
  logic rdy_q, rdy_d;
  logic tick;

  assign tick = run_q && cnt_en_i;

  always_comb begin
    run_d  = run_q;
    wave_d = wave_q;
    rdy_d  = rdy_q;
    load_o = 1'b0;
    dec_o  = 1'b0;
    if (start_i) begin
      run_d  = 1'b1;
      wave_d = 1'b1;
      rdy_d  = 1'b0;
      load_o = 1'b1;
    end else if (mode_i == MODE_TIMER) begin
      if (tick) begin
        if (hit_i) begin
          load_o = 1'b1;
          wave_d = ~wave_q;
          if (!wave_q) rdy_d = 1'b1;
        end else begin
          dec_o = 1'b1;
        end
      end
      if (stop_i) rdy_d = 1'b0;
    end else begin
      if (stop_i) begin
        run_d  = 1'b0;
        wave_d = 1'b1;
        rdy_d  = 1'b0;
      end else if (tick) begin
        dec_o = 1'b1;
        if (hit_i) begin
          wave_d = 1'b0;
          rdy_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      wave_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      wave_q <= wave_d;
      rdy_q  <= rdy_d;
    end
  end

  assign run_o  = run_q;
  assign wave_o = wave_q;
  assign rdy_o  = rdy_q;

  AST_STOP_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !rdy_q); // R5
  AST_START_WAVE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> wave_q && !rdy_q && run_q); // R6
  AST_CNT_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_COUNT && stop_i && !start_i |=> !run_q && wave_q); // R10
  AST_TMR_STOP_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_TIMER && stop_i && run_q |=> run_q); // R5
  AST_CNT_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_COUNT && tick && hit_i && !start_i && !stop_i |=> rdy_q && !wave_q); // R9
  AST_TMR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_TIMER && tick && hit_i && !start_i |=> wave_q != $past(wave_q)); // R3
endmodule

// File: rtl/cnt_timer_rdmux.sv
`timescale 1ns/1ps
module cnt_timer_rdmux #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = CNT_W / BYTE_W,
  parameter int unsigned SEL_W  = 1
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] lanes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = cnt_i[g*BYTE_W +: BYTE_W];
  end

  assign data_o = lanes[sel_i];
endmodule

// File: rtl/cnt_timer_top.sv
`timescale 1ns/1ps
module cnt_timer_top
  import cnt_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CNT_W-1:0] PRE_RST = '1,
  localparam int unsigned NBYTES = CNT_W / BYTE_W,
  localparam int unsigned SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_timer_i,
  input  logic              cnt_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              pre_we_i,
  input  logic [SEL_W-1:0]  pre_sel_i,
  input  logic [BYTE_W-1:0] pre_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rdy_o,
  output logic              wave_o
);
  logic             rst_n;
  logic [CNT_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             hit, load, dec, run;
  ct_mode_e         mode;

  assign mode = ct_mode_e'(mode_timer_i);

  cnt_timer_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  cnt_timer_preload #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES), .SEL_W(SEL_W), .PRE_RST(PRE_RST)
  ) preload_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .we_i  (pre_we_i),
    .sel_i (pre_sel_i),
    .data_i(pre_data_i),
    .pre_o (pre)
  );

  cnt_timer_ctrl ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .mode_i  (mode),
    .cnt_en_i(cnt_en_i),
    .start_i (start_i),
    .stop_i  (stop_i),
    .hit_i   (hit),
    .load_o  (load),
    .dec_o   (dec),
    .run_o   (run),
    .wave_o  (wave_o),
    .rdy_o   (rdy_o)
  );

  cnt_timer_dcnt #(.CNT_W(CNT_W)) dcnt_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .load_i(load),
    .dec_i (dec),
    .pre_i (pre),
    .cnt_o (cnt),
    .hit_o (hit)
  );

  cnt_timer_rdmux #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES), .SEL_W(SEL_W)
  ) rdmux_i (
    .cnt_i (cnt),
    .sel_i (rd_sel_i),
    .data_o(rd_data_o)
  );

  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run && !start_i |=> $stable(cnt)); // R1
  AST_TMR_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode == MODE_TIMER && run && cnt_en_i && hit && !start_i |=> cnt == $past(pre)); // R7
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> cnt == $past(pre)); // R13
  AST_CNT_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode == MODE_COUNT && !cnt_en_i && !start_i |=> $stable(cnt)); // R8
endmodule

// File: tb/cnt_timer_top_tb_top.sv
`timescale 1ns/1ps
module cnt_timer_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       mode_timer_i, cnt_en_i, start_i, stop_i, pre_we_i;
  logic [0:0] pre_sel_i, rd_sel_i;
  logic [7:0] pre_data_i, rd_data_o;
  logic       rdy_o, wave_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic        w;
    logic        r;
    logic [15:0] c;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  cnt_timer_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_timer_i(mode_timer_i), .cnt_en_i(cnt_en_i),
    .start_i(start_i), .stop_i(stop_i), .pre_we_i(pre_we_i), .pre_sel_i(pre_sel_i),
    .pre_data_i(pre_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .rdy_o(rdy_o), .wave_o(wave_o)
  );

  // Monitor: samples 1 ns after each falling edge, reads both count bytes (R12).
  always begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] hi, lo;
      e = exp_q.pop_front();
      rd_sel_i = 1'b1; #1; hi = rd_data_o;
      rd_sel_i = 1'b0; #1; lo = rd_data_o;
      n_chk++;
      if (wave_o !== e.w || rdy_o !== e.r || {hi, lo} !== e.c) begin
        n_fail++;
        $display("FAIL %s/R12: wave=%0b rdy=%0b cnt=%04h, expected wave=%0b rdy=%0b cnt=%04h",
                 e.tag, wave_o, rdy_o, {hi, lo}, e.w, e.r, e.c);
      end
    end
  end

  task automatic expect_st(input string tag, input logic w, input logic r, input logic [15:0] c);
    exp_t e;
    e.tag = tag; e.w = w; e.r = r; e.c = c;
    exp_q.push_back(e);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic p);
    start_i = s; stop_i = p;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic wr_pre(input logic [15:0] v);
    pre_we_i = 1'b1; pre_sel_i = 1'b1; pre_data_i = v[15:8];
    @(negedge clk);
    pre_sel_i = 1'b0; pre_data_i = v[7:0];
    @(negedge clk);
    pre_we_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; mode_timer_i = 1'b1; cnt_en_i = 1'b1; start_i = 1'b0; stop_i = 1'b0;
    pre_we_i = 1'b0; pre_sel_i = 1'b0; pre_data_i = '0; rd_sel_i = 1'b0;
    wt(3);
    expect_st("R1 in reset", 1'b1, 1'b0, 16'h0000);
    rst_ni = 1'b1;
    wt(4);
    expect_st("R1 after reset", 1'b1, 1'b0, 16'h0000);
    wt(3);
    expect_st("R1 no count before start", 1'b1, 1'b0, 16'h0000);

    // Timer mode, N = 4
    wr_pre(16'h0004);
    expect_st("R2 preload not visible", 1'b1, 1'b0, 16'h0000);
    pulse(1'b1, 1'b0);
    expect_st("R3 start loads", 1'b1, 1'b0, 16'h0004);
    wt(3);
    expect_st("R3 high phase", 1'b1, 1'b0, 16'h0001);
    wt(1);
    expect_st("R3 toggle low", 1'b0, 1'b0, 16'h0004);
    wt(4);
    expect_st("R4 rdy after period", 1'b1, 1'b1, 16'h0004);
    wt(1);
    expect_st("R4 rdy held", 1'b1, 1'b1, 16'h0003);
    pulse(1'b0, 1'b1);
    expect_st("R5 stop clears rdy only", 1'b1, 1'b0, 16'h0002);
    wt(2);
    expect_st("R5 still running", 1'b0, 1'b0, 16'h0004);
    wt(1);
    pulse(1'b1, 1'b0);
    expect_st("R6 restart", 1'b1, 1'b0, 16'h0004);
    wt(4);
    expect_st("R6 half period", 1'b0, 1'b0, 16'h0004);
    wr_pre(16'h0006);
    wt(2);
    expect_st("R7 old half period kept", 1'b1, 1'b1, 16'h0006);
    wt(5);
    expect_st("R7 new half period", 1'b1, 1'b1, 16'h0001);
    wt(1);
    expect_st("R7 new toggle", 1'b0, 1'b1, 16'h0006);

    // Counter mode
    mode_timer_i = 1'b0;
    pulse(1'b0, 1'b1);
    expect_st("R10 stop", 1'b1, 1'b0, 16'h0006);
    wt(3);
    expect_st("R10 halted", 1'b1, 1'b0, 16'h0006);
    wr_pre(16'h0003);
    pulse(1'b1, 1'b0);
    expect_st("R8 start loads", 1'b1, 1'b0, 16'h0003);
    cnt_en_i = 1'b0;
    wt(3);
    expect_st("R8 hold without enable", 1'b1, 1'b0, 16'h0003);
    cnt_en_i = 1'b1;
    wt(1);
    expect_st("R8 decrement", 1'b1, 1'b0, 16'h0002);
    wt(1);
    expect_st("R9 before terminal", 1'b1, 1'b0, 16'h0001);
    wt(1);
    expect_st("R9 terminal", 1'b0, 1'b1, 16'h0000);
    wt(1);
    expect_st("R9 wrap", 1'b0, 1'b1, 16'hFFFF);
    wr_pre(16'h0102);
    expect_st("R11 running unaffected", 1'b0, 1'b1, 16'hFFFD);
    pulse(1'b0, 1'b1);
    expect_st("R10 stop after terminal", 1'b1, 1'b0, 16'hFFFD);
    wt(2);
    expect_st("R10 count held", 1'b1, 1'b0, 16'hFFFD);
    pulse(1'b1, 1'b0);
    expect_st("R11 new preload", 1'b1, 1'b0, 16'h0102);
    wt(2);
    expect_st("R12 byte lanes", 1'b1, 1'b0, 16'h0100);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    expect_st("R11 reuse preload", 1'b1, 1'b0, 16'h0102);
    wt(1);
    pulse(1'b1, 1'b1);
    expect_st("R13 start beats stop", 1'b1, 1'b0, 16'h0102);
    wt(1);
    expect_st("R13 still running", 1'b1, 1'b0, 16'h0101);
    pre_we_i = 1'b1; pre_sel_i = 1'b0; pre_data_i = 8'h05;
    pulse(1'b1, 1'b0);
    pre_we_i = 1'b0;
    expect_st("R13 start uses old preload", 1'b1, 1'b0, 16'h0102);
    pulse(1'b1, 1'b0);
    expect_st("R2 low byte written", 1'b1, 1'b0, 16'h0105);

    wt(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule